// File: doc/BRIEF.md
# Double-Rate Pad Output Slice

This block is the core-to-pad output slice of a general-purpose I/O cell. It has two independent lanes, and each turns slow, wide words from the core into one pad-side bit. The data lane serializes a four-bit word onto the pad within every half-rate clock period. It does this in two steps. A half-rate stage splits the word into two pairs, one pair per full-rate cycle. A full-rate stage then drives the first bit of each pair while the full-rate clock is high and the second while it is low.

The output-enable lane is lighter. It has one half-rate stage and one plain full-rate register, and a run-time select chooses one of three modes. In pass-through mode the core's enable goes straight to the pad. In single-register mode it is retimed on the full-rate clock. In half-rate serial mode a two-bit enable word is played out one bit per full-rate cycle. A pad enable of 0 means the pad driver is tri-stated. A build parameter marks the slice as belonging to a low-voltage bank. Such a bank has no double-rate hardware, so both lanes fall back to a single full-rate register.

The full-rate clock must run at exactly twice the half-rate clock, with its rising edges aligned to it. Reset is synchronous and active high. It must be released after a half-rate rising edge and before the next full-rate rising edge.

Top module: `gpo_slice`

## Requirements
- R1: With `LV_BANK` = 0, a word on `dat_word` sampled at half-rate edge T appears on `pad_dat` in bit order 0, 1, 2, 3. Each bit lasts half a full-rate period, and bit 0 starts at the full-rate rising edge T+1 full-rate cycle.
- R2: In the double-rate data lane, bits 0 and 2 are driven while `clk_fr` is high and bits 1 and 3 while it is low.
- R3: When mode 2'b00 (pass-through) is in force, `pad_oe` follows `oe_word[0]` with no register in the path.
- R4: When mode 2'b01 (single register) is in force, `pad_oe` holds, for one full-rate cycle, the `oe_word[0]` value sampled at the full-rate edge that starts that cycle.
- R5: When mode 2'b10 (half-rate serial) is in force, the `oe_word` value sampled at half-rate edge T is shown in two steps. `oe_word[0]` is driven during the full-rate cycle that starts at T+1 full-rate cycle, and `oe_word[1]` during the cycle that follows.
- R6: Mode code 2'b11 behaves exactly as pass-through.
- R7: `oe_mode` is sampled only at half-rate rising edges. It takes effect at the next mid-period full-rate edge and holds for two whole full-rate cycles, so no enable bit is cut short.
- R8: While `rst` is high, `pad_dat` and `pad_oe` are 0 at once. Reset leaves the mode at pass-through and all lane registers at 0.
- R9: With `LV_BANK` = 1, `pad_dat` is `dat_word[0]` registered on each full-rate edge, and mode 2'b10 acts as single register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_hr | input | 1 | Half-rate clock, rising edge aligned with `clk_fr` |
| clk_fr | input | 1 | Full-rate clock at twice the half-rate frequency |
| rst | input | 1 | Synchronous active-high reset; forces both pad outputs to 0 |
| dat_word | input | 4 | Data word from the core, one per half-rate cycle, bit 0 sent first |
| oe_word | input | 2 | Enable word from the core; bit 0 only outside half-rate serial mode |
| oe_mode | input | 2 | Enable mode: 00 pass-through, 01 single register, 10 half-rate serial, 11 as 00 |
| pad_dat | output | 1 | Serialized data to the pad driver |
| pad_oe | output | 1 | Pad driver enable; 0 means tri-stated |

## Verification
A phase register out of step with the half-rate clock swaps the two bit pairs. The pad then shows bits 2,3 where 0,1 belong, or the enable bits in reverse order, and this is visible within the first half-rate period after reset. A stale or mistimed mode register shows up as a one-cycle slip or a stray pass-through value on `pad_oe` within one or two full-rate cycles of a mode change. A fault in the full-rate clock select is visible at once: it mismatches the half-cycle samples of `pad_dat` in every period.

// File: rtl/gpo_pkg.sv
`timescale 1ns/1ps
package gpo_pkg;
  // serialization width per half-rate cycle and per full-rate cycle
  localparam int unsigned SER_W  = 4;
  localparam int unsigned PAIR_W = SER_W / 2;

  typedef enum logic [1:0] {
    OE_BYPASS = 2'b00,
    OE_PACKED = 2'b01,
    OE_HALF   = 2'b10,
    OE_RSVD   = 2'b11
  } oe_mode_e;

  // fold a raw mode code into the mode that the bank can run
  function automatic oe_mode_e legal_mode(input logic [1:0] raw, input bit lv);
    case (raw)
      2'b01:   legal_mode = OE_PACKED;
      2'b10:   legal_mode = lv ? OE_PACKED : OE_HALF;
      default: legal_mode = OE_BYPASS;
    endcase
  endfunction

  // pair of bits the full-rate stage loads: early pair mid-period, late pair on the boundary
  function automatic logic [PAIR_W-1:0] pick_pair(input logic [SER_W-1:0] w, input logic late);
    pick_pair = late ? w[SER_W-1:PAIR_W] : w[PAIR_W-1:0];
  endfunction
endpackage

// File: rtl/gpo_phase.sv
`timescale 1ns/1ps
// at_bound is high in the full-rate cycle whose closing edge is a half-rate edge
module gpo_phase (
  input  logic clk_fr,
  input  logic rst,
  output logic at_bound
);
  always_ff @(posedge clk_fr) begin
    if (rst) at_bound <= 1'b0;
    else     at_bound <= ~at_bound;
  end
endmodule

// File: rtl/gpo_hr_reg.sv
`timescale 1ns/1ps
module gpo_hr_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk_hr,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk_hr) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/gpo_dat_path.sv
`timescale 1ns/1ps
module gpo_dat_path import gpo_pkg::*; #(
  parameter bit LV_BANK = 1'b0
) (
  input  logic             clk_hr,
  input  logic             clk_fr,
  input  logic             rst,
  input  logic             at_bound,
  input  logic [SER_W-1:0] dat_word,
  output logic             pad_d
);
  generate
    if (LV_BANK == 1'b0) begin : g_ddr
      logic [SER_W-1:0]  dat_q;
      logic [PAIR_W-1:0] pair_q;

      gpo_hr_reg #(.W(SER_W)) u_hr (
        .clk_hr (clk_hr),
        .rst    (rst),
        .d      (dat_word),
        .q      (dat_q)
      );

      always_ff @(posedge clk_fr) begin
        if (rst) pair_q <= '0;
        else     pair_q <= pick_pair(dat_q, at_bound);
      end

      // clock-select: first bit of the pair in the high phase, second in the low phase
      assign pad_d = clk_fr ? pair_q[0] : pair_q[1];
    end else begin : g_sdr
      logic bit_q;
      always_ff @(posedge clk_fr) begin
        if (rst) bit_q <= 1'b0;
        else     bit_q <= dat_word[0];
      end
      assign pad_d = bit_q;
    end
  endgenerate
endmodule

// File: rtl/gpo_oe_path.sv
`timescale 1ns/1ps
module gpo_oe_path import gpo_pkg::*; #(
  parameter bit LV_BANK = 1'b0
) (
  input  logic              clk_hr,
  input  logic              clk_fr,
  input  logic              rst,
  input  logic              at_bound,
  input  logic [PAIR_W-1:0] oe_word,
  input  logic [1:0]        oe_mode,
  output oe_mode_e          mode_act,
  output logic              pad_e
);
  logic [1:0]        mode_raw_q;
  oe_mode_e          mode_q;
  oe_mode_e          mode_eff;
  logic [PAIR_W-1:0] oe_q;
  logic              oe_fr;

  // mode is taken at the half-rate boundary only
  gpo_hr_reg #(.W(2)) u_mode (
    .clk_hr (clk_hr),
    .rst    (rst),
    .d      (legal_mode(oe_mode, LV_BANK)),
    .q      (mode_raw_q)
  );
  assign mode_q = oe_mode_e'(mode_raw_q);

  generate
    if (LV_BANK == 1'b0) begin : g_hr
      gpo_hr_reg #(.W(PAIR_W)) u_oe (
        .clk_hr (clk_hr),
        .rst    (rst),
        .d      (oe_word),
        .q      (oe_q)
      );
    end else begin : g_no_hr
      assign oe_q = '0;
    end
  endgenerate

  // switch over at the mid-period edge, where a serial enable word starts
  always_ff @(posedge clk_fr) begin
    if (rst)            mode_act <= OE_BYPASS;
    else if (!at_bound) mode_act <= mode_q;
  end

  // mode that governs the value loaded at the coming edge
  assign mode_eff = at_bound ? mode_act : mode_q;

  always_ff @(posedge clk_fr) begin
    if (rst)                     oe_fr <= 1'b0;
    else if (mode_eff == OE_HALF) oe_fr <= oe_q[at_bound];
    else                         oe_fr <= oe_word[0];
  end

  assign pad_e = (mode_act == OE_BYPASS) ? oe_word[0] : oe_fr;
endmodule

// File: rtl/gpo_slice.sv
`timescale 1ns/1ps
module gpo_slice import gpo_pkg::*; #(
  parameter bit LV_BANK = 1'b0
) (
  input  logic              clk_hr,
  input  logic              clk_fr,
  input  logic              rst,
  input  logic [SER_W-1:0]  dat_word,
  input  logic [PAIR_W-1:0] oe_word,
  input  logic [1:0]        oe_mode,
  output logic              pad_dat,
  output logic              pad_oe
);
  logic     at_bound;
  oe_mode_e mode_act;
  logic     pad_d_raw;
  logic     pad_e_raw;

  gpo_phase u_phase (
    .clk_fr   (clk_fr),
    .rst      (rst),
    .at_bound (at_bound)
  );

  gpo_dat_path #(.LV_BANK(LV_BANK)) u_dat (
    .clk_hr   (clk_hr),
    .clk_fr   (clk_fr),
    .rst      (rst),
    .at_bound (at_bound),
    .dat_word (dat_word),
    .pad_d    (pad_d_raw)
  );

  gpo_oe_path #(.LV_BANK(LV_BANK)) u_oe (
    .clk_hr   (clk_hr),
    .clk_fr   (clk_fr),
    .rst      (rst),
    .at_bound (at_bound),
    .oe_word  (oe_word),
    .oe_mode  (oe_mode),
    .mode_act (mode_act),
    .pad_e    (pad_e_raw)
  );

  // pads inactive (driver off) for as long as reset is held
  assign pad_dat = rst ? 1'b0 : pad_d_raw;
  assign pad_oe  = rst ? 1'b0 : pad_e_raw;
endmodule

// File: rtl/gpo_slice_chk.sv
`timescale 1ns/1ps
module gpo_slice_chk import gpo_pkg::*; #(
  parameter bit LV_BANK = 1'b0
) (
  input logic              clk_fr,
  input logic              rst,
  input logic              at_bound,
  input oe_mode_e          mode_act,
  input logic [PAIR_W-1:0] oe_word,
  input logic              pad_oe
);
  AST_RST_MODE: assert property (@(posedge clk_fr)
    rst |=> (mode_act == OE_BYPASS)); // R8

  AST_PHASE_TOGGLE: assert property (@(posedge clk_fr) disable iff (rst)
    1'b1 |=> (at_bound != $past(at_bound))); // R7

  AST_MODE_HOLD: assert property (@(posedge clk_fr) disable iff (rst)
    at_bound |=> $stable(mode_act)); // R7

  AST_MODE_LEGAL: assert property (@(posedge clk_fr) disable iff (rst)
    mode_act != OE_RSVD); // R6

  AST_LV_NO_HALF: assert property (@(posedge clk_fr) disable iff (rst)
    !(LV_BANK && (mode_act == OE_HALF))); // R9

  AST_BYPASS_LIVE: assert property (@(negedge clk_fr) disable iff (rst)
    (mode_act == OE_BYPASS) |-> (pad_oe == oe_word[0])); // R3

  AST_PACKED_RETIME: assert property (@(posedge clk_fr) disable iff (rst)
    (at_bound && mode_act == OE_PACKED) |=> (pad_oe == $past(oe_word[0]))); // R4

  AST_HALF_LATE_BIT: assert property (@(posedge clk_fr) disable iff (rst)
    (at_bound && mode_act == OE_HALF) |=> (pad_oe == $past(oe_word[1], 3))); // R5
endmodule

bind gpo_slice gpo_slice_chk #(.LV_BANK(LV_BANK)) u_chk (
  .clk_fr   (clk_fr),
  .rst      (rst),
  .at_bound (at_bound),
  .mode_act (mode_act),
  .oe_word  (oe_word),
  .pad_oe   (pad_oe)
);

// File: tb/test_gpo_slice.sv
`timescale 1ns/1ps
module test_gpo_slice;
  typedef struct packed {
    logic [3:0] d;
    logic [1:0] e;
    logic [1:0] m;
  } stim_t;

  logic       clk_fr = 1'b0;
  logic       clk_hr = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] dat_word = 4'h0;
  logic [1:0] oe_word = 2'b00;
  logic [1:0] oe_mode = 2'b00;
  logic       pad_dat, pad_oe, pad_dat_lv, pad_oe_lv;
  int         total = 0;
  int         bad = 0;

  initial forever #5 clk_fr = ~clk_fr;
  initial begin
    #5;
    forever begin
      clk_hr = 1'b1; #10;
      clk_hr = 1'b0; #10;
    end
  end

  gpo_slice #(.LV_BANK(1'b0)) i_gpo_slice (
    .clk_hr (clk_hr), .clk_fr (clk_fr), .rst (rst),
    .dat_word (dat_word), .oe_word (oe_word), .oe_mode (oe_mode),
    .pad_dat (pad_dat), .pad_oe (pad_oe)
  );

  gpo_slice #(.LV_BANK(1'b1)) i_gpo_slice_lv (
    .clk_hr (clk_hr), .clk_fr (clk_fr), .rst (rst),
    .dat_word (dat_word), .oe_word (oe_word), .oe_mode (oe_mode),
    .pad_dat (pad_dat_lv), .pad_oe (pad_oe_lv)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // 0 pass-through, 1 single register, 2 half-rate serial
  function automatic int run_mode(input logic [1:0] raw, input bit lv);
    if (raw == 2'd1) return 1;
    if (raw == 2'd2) return lv ? 1 : 2;
    return 0;
  endfunction

  function automatic string tag(input int md, input logic [1:0] raw, input bit lv);
    string s;
    s = (md == 0) ? ((raw == 2'd3) ? "R6 R3" : "R3") : (md == 1) ? "R4" : "R5";
    if (lv) s = {s, " R9"};
    return {s, " R7"};
  endfunction

  // expected enable in one full-rate cycle; byp = live bit, pak = retimed bit, hlf = serial bit
  function automatic logic oe_ref(input int md, input logic byp, input logic pak, input logic hlf);
    return (md == 0) ? byp : (md == 1) ? pak : hlf;
  endfunction

  function automatic stim_t gen(input int i);
    stim_t s;
    logic [7:0] v;
    v   = i[7:0];
    s.d = v[3:0] ^ {v[5:4], v[7:6]};
    s.e = v[1:0] ^ v[6:5];
    s.m = (i < 128) ? v[5:4] : (v[1:0] ^ v[3:2]);
    return s;
  endfunction

  task automatic apply(input stim_t s);
    dat_word = s.d;
    oe_word  = s.e;
    oe_mode  = s.m;
  endtask

  initial begin : watchdog
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    stim_t prev, cur, nxt;
    int    m0, m1, l0, l1;

    // R8: pads forced off during reset even with live enable requested
    apply('{d: 4'hF, e: 2'b11, m: 2'b00});
    repeat (3) @(posedge clk_hr);
    #2.5;
    chk("R8 reset pad_dat", pad_dat, 1'b0);
    chk("R8 reset pad_oe", pad_oe, 1'b0);
    chk("R8 reset pad_dat lv", pad_dat_lv, 1'b0);
    chk("R8 reset pad_oe lv", pad_oe_lv, 1'b0);

    @(posedge clk_hr);
    #2;
    rst  = 1'b0;
    prev = '0;
    cur  = gen(0);
    apply(cur);

    for (int i = 1; i <= 400; i++) begin
      @(posedge clk_hr);
      #2;
      nxt = gen(i);
      apply(nxt);
      m0 = run_mode(prev.m, 1'b0);
      m1 = run_mode(cur.m, 1'b0);
      l0 = run_mode(prev.m, 1'b1);
      l1 = run_mode(cur.m, 1'b1);

      #0.5; // clk_fr high, cycle opened by the half-rate edge
      chk("R1 R2 bit2 high phase", pad_dat, prev.d[2]);
      chk(tag(m0, prev.m, 1'b0), pad_oe, oe_ref(m0, nxt.e[0], cur.e[0], prev.e[1]));
      chk("R9 lv data", pad_dat_lv, cur.d[0]);
      chk(tag(l0, prev.m, 1'b1), pad_oe_lv, oe_ref(l0, nxt.e[0], cur.e[0], 1'b0));
      #5;   // clk_fr low
      chk("R1 R2 bit3 low phase", pad_dat, prev.d[3]);
      chk(tag(m0, prev.m, 1'b0), pad_oe, oe_ref(m0, nxt.e[0], cur.e[0], prev.e[1]));
      chk("R9 lv data", pad_dat_lv, cur.d[0]);
      chk(tag(l0, prev.m, 1'b1), pad_oe_lv, oe_ref(l0, nxt.e[0], cur.e[0], 1'b0));
      #5;   // clk_fr high, mid-period cycle
      chk("R1 R2 bit0 high phase", pad_dat, cur.d[0]);
      chk(tag(m1, cur.m, 1'b0), pad_oe, oe_ref(m1, nxt.e[0], nxt.e[0], cur.e[0]));
      chk("R9 lv data", pad_dat_lv, nxt.d[0]);
      chk(tag(l1, cur.m, 1'b1), pad_oe_lv, oe_ref(l1, nxt.e[0], nxt.e[0], 1'b0));
      #5;   // clk_fr low
      chk("R1 R2 bit1 low phase", pad_dat, cur.d[1]);
      chk(tag(m1, cur.m, 1'b0), pad_oe, oe_ref(m1, nxt.e[0], nxt.e[0], cur.e[0]));
      chk("R9 lv data", pad_dat_lv, nxt.d[0]);
      chk(tag(l1, cur.m, 1'b1), pad_oe_lv, oe_ref(l1, nxt.e[0], nxt.e[0], 1'b0));

      prev = cur;
      cur  = nxt;
    end

    // R8: asserting reset mid-run silences the pads at once
    @(posedge clk_hr);
    #2;
    oe_mode  = 2'b00;
    oe_word  = 2'b11;
    dat_word = 4'hF;
    rst      = 1'b1;
    #0.5;
    chk("R8 reset entry pad_oe", pad_oe, 1'b0);
    chk("R8 reset entry pad_dat", pad_dat, 1'b0);
    chk("R8 reset entry pad_oe lv", pad_oe_lv, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule